// File: doc/BRIEF.md
# Channelized Spectrum Packetizer

This block takes a stream of channelized spectra and turns it into fixed-length packets for a small set of destinations. Each input beat carries one channel of one spectrum: an 8-bit real and an 8-bit imaginary sample for each of two polarizations. The channels of a spectrum arrive in ascending order, and the first channel of each spectrum carries a start marker. Each destination owns one contiguous range of channels. The range size is the channel count divided by the destination count, and both counts are powers of two. The block routes every sample to its destination's buffer using shifts only.

Once a destination has collected a full packet's worth of payload, the block sends a burst on a 64-bit valid/last stream. The burst is a timestamp beat, then an ID beat, then the payload words. A destination index travels alongside the burst so that downstream framing logic can look up that destination's IP address and port registers. While a burst is on the output, the input is held off through a ready signal, so no sample is lost. The timestamp is a 64-bit spectrum counter that a sync pulse clears.

Top module: `spec_packetizer`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0 and `outLast` is 0.
- R2: A sample of channel c (0-based, counted from the last start marker) is routed to destination c >> log2(NUM_CHAN/NUM_DEST). `outDest` shows that destination and holds steady for every beat of the burst.
- R3: The first beat of every burst is the 64-bit timestamp. The timestamp of a spectrum is the number of start-marked beats accepted since the last sync pulse, its own included. The first spectrum after a sync therefore has timestamp 1.
- R4: The second beat is the ID: the 1-based number of the destination's first channel, dest*(NUM_CHAN/NUM_DEST)+1. When channels equal destinations, this is the channel's own 1-based number.
- R5: Payload word k holds samples 2k and 2k+1 of the destination's sample sequence, in arrival order. The earlier sample sits in bits 63:32. Each 32-bit sample is laid out as pol0 real [31:24], pol0 imag [23:16], pol1 real [15:8], pol1 imag [7:0].
- R6: A burst is exactly WORDS_PER_PKT+2 consecutive valid beats. `outLast` is 1 only on the final payload beat.
- R7: A burst starts in the cycle after the accepted beat that completes a packet. `inReady` is 0 for every cycle in which `outValid` is 1 and returns to 1 after the last beat. Every sample offered while `inValid` is 1 is eventually accepted and appears in exactly one packet.
- R8: A sync pulse clears the spectrum counter. A start-marked beat accepted in the same cycle counts as 1 after the clear.
- R9: A packet's timestamp is the timestamp of the spectrum that supplied the packet's first sample, even when the packet spans several spectra.
- R10: A start marker restarts the channel count at 0 even if the previous spectrum was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inSync | input | 1 | Clears the spectrum counter |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high together with inValid |
| inSof | input | 1 | Beat is channel 0 of a new spectrum |
| inSample | input | 32 | Two-polarization complex sample, lanes as in R5 |
| outValid | output | 1 | Output beat valid |
| outData | output | 64 | Timestamp, ID or payload word |
| outLast | output | 1 | Final payload beat of a packet |
| outDest | output | log2(NUM_DEST) | Destination index of the current burst |

## Verification
The hardest case to reach is a packet whose samples span several spectra while a sync pulse lands in between. Its header must then carry the stamp of its first sample and not a later one. A second hard case is a start marker that arrives before a spectrum is complete. The stimulus runs long sequences of full spectra with random idle gaps, inserts sync pulses in the middle of partly filled packets, and sends a truncated spectrum. A scoreboard model predicts every output beat from the requirement rules alone.

// File: rtl/spec_pkt_pkg.sv
package spec_pkt_pkg;

  typedef enum logic [1:0] {
    BEAT_IDLE = 2'd0,
    BEAT_HDR0 = 2'd1,
    BEAT_HDR1 = 2'd2,
    BEAT_PAY  = 2'd3
  } beatSel_e;

  typedef struct packed {
    logic     specStart;
    logic     capFirst;
    logic     capSecond;
    logic     latchStamp;
    beatSel_e sel;
  } pktStrobe_t;

endpackage

// File: rtl/spec_pkt_ctrl.sv
module spec_pkt_ctrl
  import spec_pkt_pkg::*;
#(
  parameter int NUM_CHAN      = 8,
  parameter int NUM_DEST      = 4,
  parameter int WORDS_PER_PKT = 4,
  localparam int CPD   = NUM_CHAN / NUM_DEST,
  localparam int SHIFT = $clog2(CPD),
  localparam int CW    = $clog2(NUM_CHAN),
  localparam int DW    = $clog2(NUM_DEST),
  localparam int PW    = $clog2(WORDS_PER_PKT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  output logic          inReady,
  output pktStrobe_t    strobe,
  output logic [DW-1:0] capDest,
  output logic [PW-1:0] capWord,
  output logic [DW-1:0] emitDest,
  output logic [PW-1:0] payIdx,
  output logic          outValid,
  output logic          outLast
);

  beatSel_e      state;
  logic [CW-1:0] chanCnt;
  logic [CW-1:0] beatChan;
  logic [DW-1:0] beatDest;
  logic          acc;
  logic          pktDone;
  logic [NUM_DEST-1:0] halfFull;
  logic [PW-1:0] wordCnt [NUM_DEST];

  assign inReady  = (state == BEAT_IDLE);
  assign acc      = inValid && inReady;
  assign beatChan = inSof ? '0 : chanCnt;
  assign beatDest = beatChan[CW-1 -: DW];

  assign capDest  = beatDest;
  assign capWord  = wordCnt[beatDest];
  assign pktDone  = acc && halfFull[beatDest] && (wordCnt[beatDest] == PW'(WORDS_PER_PKT - 1));

  always_comb begin
    strobe            = '0;
    strobe.specStart  = acc && inSof;
    strobe.capFirst   = acc && !halfFull[beatDest];
    strobe.capSecond  = acc && halfFull[beatDest];
    strobe.latchStamp = acc && !halfFull[beatDest] && (wordCnt[beatDest] == '0);
    strobe.sel        = state;
  end

  // channel position within the current spectrum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCnt <= '0;
    end else if (acc) begin
      chanCnt <= (beatChan == CW'(NUM_CHAN - 1)) ? '0 : beatChan + 1'b1;
    end
  end

  // per-destination fill state
  generate
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_fill
      always_ff @(posedge clk) begin
        if (!rstN) begin
          halfFull[d] <= 1'b0;
          wordCnt[d]  <= '0;
        end else if (acc && beatDest == DW'(d)) begin
          if (halfFull[d]) begin
            halfFull[d] <= 1'b0;
            wordCnt[d]  <= wordCnt[d] + 1'b1;
          end else begin
            halfFull[d] <= 1'b1;
          end
        end
      end
    end
  endgenerate

  // burst sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BEAT_IDLE;
      payIdx   <= '0;
      emitDest <= '0;
    end else begin
      case (state)
        BEAT_IDLE: if (pktDone) begin
          state    <= BEAT_HDR0;
          emitDest <= beatDest;
        end
        BEAT_HDR0: state <= BEAT_HDR1;
        BEAT_HDR1: begin
          state  <= BEAT_PAY;
          payIdx <= '0;
        end
        default: begin
          if (payIdx == PW'(WORDS_PER_PKT - 1)) state <= BEAT_IDLE;
          payIdx <= payIdx + 1'b1;
        end
      endcase
    end
  end

  assign outValid = (state != BEAT_IDLE);
  assign outLast  = (state == BEAT_PAY) && (payIdx == PW'(WORDS_PER_PKT - 1));

  assert_hdr_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == BEAT_HDR0) |=> (state == BEAT_HDR1));
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
  assert_dest_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> $stable(emitDest));

endmodule

// File: rtl/spec_pkt_datapath.sv
module spec_pkt_datapath
  import spec_pkt_pkg::*;
#(
  parameter int NUM_CHAN      = 8,
  parameter int NUM_DEST      = 4,
  parameter int WORDS_PER_PKT = 4,
  localparam int CPD   = NUM_CHAN / NUM_DEST,
  localparam int SHIFT = $clog2(CPD),
  localparam int DW    = $clog2(NUM_DEST),
  localparam int PW    = $clog2(WORDS_PER_PKT),
  localparam int DEPTH = NUM_DEST * WORDS_PER_PKT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inSync,
  input  logic [31:0]   inSample,
  input  pktStrobe_t    strobe,
  input  logic [DW-1:0] capDest,
  input  logic [PW-1:0] capWord,
  input  logic [DW-1:0] emitDest,
  input  logic [PW-1:0] payIdx,
  output logic [63:0]   outData
);

  logic [63:0] tsCnt;
  logic [63:0] tsNext;
  logic [31:0] halfReg  [NUM_DEST];
  logic [63:0] stampReg [NUM_DEST];
  logic [63:0] payMem   [DEPTH];
  logic [63:0] idWord;

  assign tsNext = (inSync ? 64'd0 : tsCnt) + 64'(strobe.specStart);

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsNext;
  end

  generate
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
      always_ff @(posedge clk) begin
        if (!rstN) begin
          halfReg[d]  <= '0;
          stampReg[d] <= '0;
        end else if (capDest == DW'(d)) begin
          if (strobe.capFirst)   halfReg[d]  <= inSample;
          if (strobe.latchStamp) stampReg[d] <= tsNext;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.capSecond) payMem[{capDest, capWord}] <= {halfReg[capDest], inSample};
  end

  assign idWord = (64'(emitDest) << SHIFT) + 64'd1;

  always_comb begin
    case (strobe.sel)
      BEAT_HDR0: outData = stampReg[emitDest];
      BEAT_HDR1: outData = idWord;
      BEAT_PAY:  outData = payMem[{emitDest, payIdx}];
      default:   outData = '0;
    endcase
  end

  assert_cap_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capFirst, strobe.capSecond}));
  assert_sync_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inSync && !strobe.specStart) |=> (tsCnt == 64'd0));

endmodule

// File: rtl/spec_packetizer.sv
module spec_packetizer
  import spec_pkt_pkg::*;
#(
  parameter int NUM_CHAN      = 8,
  parameter int NUM_DEST      = 4,
  parameter int WORDS_PER_PKT = 4,
  localparam int DW = $clog2(NUM_DEST),
  localparam int PW = $clog2(WORDS_PER_PKT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inSync,
  input  logic          inValid,
  output logic          inReady,
  input  logic          inSof,
  input  logic [31:0]   inSample,
  output logic          outValid,
  output logic [63:0]   outData,
  output logic          outLast,
  output logic [DW-1:0] outDest
);

  pktStrobe_t    strobe;
  logic [DW-1:0] capDest;
  logic [PW-1:0] capWord;
  logic [DW-1:0] emitDest;
  logic [PW-1:0] payIdx;

  spec_pkt_ctrl #(
    .NUM_CHAN(NUM_CHAN), .NUM_DEST(NUM_DEST), .WORDS_PER_PKT(WORDS_PER_PKT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inReady(inReady),
    .strobe(strobe), .capDest(capDest), .capWord(capWord), .emitDest(emitDest),
    .payIdx(payIdx), .outValid(outValid), .outLast(outLast)
  );

  spec_pkt_datapath #(
    .NUM_CHAN(NUM_CHAN), .NUM_DEST(NUM_DEST), .WORDS_PER_PKT(WORDS_PER_PKT)
  ) uData (
    .clk(clk), .rstN(rstN), .inSync(inSync), .inSample(inSample), .strobe(strobe),
    .capDest(capDest), .capWord(capWord), .emitDest(emitDest), .payIdx(payIdx),
    .outData(outData)
  );

  assign outDest = emitDest;

endmodule

// File: tb/spec_packetizer_test.sv
module spec_packetizer_test;

  localparam int NUM_CHAN = 8;
  localparam int NUM_DEST = 4;
  localparam int WPP      = 4;
  localparam int CPD      = NUM_CHAN / NUM_DEST;
  localparam int DW       = $clog2(NUM_DEST);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inSync = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          inSof = 1'b0;
  logic [31:0]   inSample = '0;
  logic          outValid;
  logic [63:0]   outData;
  logic          outLast;
  logic [DW-1:0] outDest;

  always #2.5 clk = ~clk;

  spec_packetizer #(.NUM_CHAN(NUM_CHAN), .NUM_DEST(NUM_DEST), .WORDS_PER_PKT(WPP)) uut (
    .clk(clk), .rstN(rstN), .inSync(inSync), .inValid(inValid), .inReady(inReady),
    .inSof(inSof), .inSample(inSample), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outDest(outDest)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit running = 1'b0;

  // scoreboard
  logic [63:0] expData[$];
  logic        expLast[$];
  int          expDest[$];
  string       expTag[$];

  // reference model state
  logic [31:0] pend[NUM_DEST][$];
  logic [63:0] stampM[NUM_DEST];
  logic [63:0] tsM = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelBeat(input bit sof, input int chan, input logic [31:0] s);
    int d;
    d = chan / CPD;                        // R2 / R10 mapping
    if (sof) tsM = tsM + 1;                // R3 counting
    if (pend[d].size() == 0) stampM[d] = tsM;  // R9 latch on first sample
    pend[d].push_back(s);
    if (pend[d].size() == 2 * WPP) begin
      expData.push_back(stampM[d]); expLast.push_back(1'b0); expDest.push_back(d); expTag.push_back("R3/R9 timestamp");
      expData.push_back(64'(d * CPD + 1)); expLast.push_back(1'b0); expDest.push_back(d); expTag.push_back("R4 id");
      for (int k = 0; k < WPP; k++) begin
        expData.push_back({pend[d][2*k], pend[d][2*k+1]});
        expLast.push_back(k == WPP - 1);
        expDest.push_back(d);
        expTag.push_back("R5/R6 payload");
      end
      pend[d].delete();
    end
  endtask

  task automatic sendBeat(input bit sof, input int chan);
    logic [31:0] s;
    s = $urandom;
    @(negedge clk);
    inValid = 1'b1; inSof = sof; inSample = s;
    while (!inReady) @(negedge clk);
    modelBeat(sof, chan, s);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0;
    end
  endtask

  task automatic sendSpectrum(input int nCh, input bit gaps);
    for (int c = 0; c < nCh; c++) begin
      sendBeat(c == 0, c);
      if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 3);
    end
  endtask

  task automatic pulseSync();
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inSync = 1'b1;
    tsM = '0;                               // R8
    @(negedge clk);
    inSync = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (running && outValid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R7 unexpected beat", outData, 64'd0);
      end else begin
        logic [63:0] eD; logic eL; int eT; string tg;
        eD = expData.pop_front(); eL = expLast.pop_front(); eT = expDest.pop_front(); tg = expTag.pop_front();
        check(outData == eD, tg, outData, eD);
        check(outLast == eL, "R6 last flag", 64'(outLast), 64'(eL));
        check(int'(outDest) == eT, "R2 destination", 64'(outDest), 64'(eT));
        check(!inReady, "R7 stall during burst", 64'(inReady), 64'd0);
      end
    end else if (running && outLast) begin
      check(1'b0, "R6 last without valid", 64'(outLast), 64'd0);
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", 64'(inReady), 64'd1);
    check(outValid == 1'b0, "R1 valid after reset", 64'(outValid), 64'd0);
    check(outLast == 1'b0, "R1 last after reset", 64'(outLast), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;

    // back-to-back full spectra
    for (int i = 0; i < 8; i++) sendSpectrum(NUM_CHAN, 1'b0);
    // spectra with idle gaps
    for (int i = 0; i < 6; i++) sendSpectrum(NUM_CHAN, 1'b1);
    // sync in the middle of partly filled packets (R8, R9)
    sendSpectrum(NUM_CHAN, 1'b0);
    pulseSync();
    for (int i = 0; i < 5; i++) sendSpectrum(NUM_CHAN, 1'b1);
    // truncated spectrum, then restart (R10)
    sendSpectrum(3, 1'b0);
    for (int i = 0; i < 8; i++) sendSpectrum(NUM_CHAN, 1'b0);
    pulseSync();
    for (int i = 0; i < 8; i++) sendSpectrum(NUM_CHAN, 1'b1);
    idle(40);

    check(expData.size() == 0, "R7 all expected beats seen", 64'(expData.size()), 64'd0);
    check(inReady == 1'b1, "R7 ready after drain", 64'(inReady), 64'd1);
    running = 1'b0;
    finishRun();
  end

endmodule